// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal single-word request port and an external asynchronous static RAM. The RAM holds 128K bytes behind a 17-bit address, an 8-bit bidirectional data bus and three active-low strobes: chip select, output enable and write enable. The controller takes one read or write request at a time through a valid/ready handshake. It drives the address and the strobes from registers, so no strobe can glitch. It returns a one-cycle acknowledge. On a read, the captured byte comes with that acknowledge.

Every timing limit of the RAM is a parameter given in picoseconds, together with the clock period. The controller rounds each limit up to a whole number of clocks, with a floor of one clock. The data bus is split into an output value, a driver enable and an input. A read holds output enable low for the longest of the access-time limits and the cycle-time limit, and it samples the bus on the last clock of that window. It then holds a float gap before the next request. A write keeps output enable high. It lowers write enable, waits out the RAM's output float time, and only then turns its own drivers on. It releases the drivers on the same edge that ends the write pulse.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and on the cycle after any reset, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only while the controller is idle. A request held on the port while a transfer runs has no effect on that transfer's address or strobes. It is accepted once the controller returns to idle.
- R3: A read (`req_write` = 0) holds `sram_ce_n` = 0, `sram_oe_n` = 0 and `sram_we_n` = 1 for N_RD cycles, starting the cycle after acceptance. N_RD is the largest of the address access time, the output-enable access time and the read cycle time, each rounded up to clocks. With the default parameters N_RD is 3.
- R4: The byte on `sram_dq_in` during the last cycle of the read window appears on `rsp_rdata`. `rsp_valid` is 1 for exactly one cycle, the first cycle after `sram_oe_n` returns to 1.
- R5: After a read, the strobes stay high with `req_ready` at 0 for N_OHZ cycles, the output-disable float time rounded up to clocks. With the default parameters N_OHZ is 1.
- R6: A write holds `sram_oe_n` = 1 throughout. `sram_ce_n` and `sram_we_n` are 0 for N_WHZ + N_DRV cycles. This is at least the write pulse width and the write cycle time in clocks. With the default parameters it is 3 cycles.
- R7: During a write, `sram_dq_oe` is 0 for the first N_WHZ cycles of the write pulse (1 by default). It is then 1 for N_DRV cycles (2 by default) with `sram_dq_out` equal to the request's data. It falls on the same edge where `sram_we_n` rises.
- R8: A write is acknowledged by a one-cycle `rsp_valid` in the first cycle after `sram_we_n` rises, with the strobes high. `rsp_rdata` keeps its previous value.
- R9: `sram_dq_oe` is never 1 unless `sram_we_n` = 0 and `sram_oe_n` = 1. The controller and the RAM therefore never drive the bus together.
- R10: `sram_addr` is stable on every cycle that `sram_ce_n` stays 0, and it equals the accepted request's address.
- R11: `sram_we_n` = 0 only together with `sram_ce_n` = 0 and `sram_oe_n` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Controller idle; request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read byte |
| sram_addr | output | 17 | RAM address bus |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_out | output | 8 | Data to be driven onto the RAM bus |
| sram_dq_oe | output | 1 | Enables the data bus drivers |
| sram_dq_in | input | 8 | Data sampled from the RAM bus |

## Verification
The hardest case to reach from the ports is a request held on the port while a transfer is already running. The held request must not disturb the live address or strobes, and it must start exactly when the controller falls idle. The bench accepts a read and then, without dropping valid, swaps the request fields to a write at a different address. It checks that the read window keeps its address and strobes, and that the write begins only after the float gap. A reset asserted in the middle of the driven phase of a write is also applied, to see the drivers and strobes come back to their idle levels at once. A bench-side RAM model answers reads only while both selects are low, so a sample taken in the wrong cycle returns a wrong byte.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACC,
        PH_RD_FLT,
        PH_WR_FLT,
        PH_WR_DRV,
        PH_WR_END
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drv;
    } strobe_t;

    // Interval in picoseconds to whole clocks, never fewer than one
    function automatic int unsigned cyc_ceil(input int unsigned t_ps,
                                             input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a,
                                         input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels that belong to each phase
    function automatic strobe_t strobes_for(input phase_e ph);
        strobe_t s;
        s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
        case (ph)
            PH_RD_ACC: begin
                s.ce_n = 1'b0;
                s.oe_n = 1'b0;
            end
            PH_WR_FLT: begin
                s.ce_n = 1'b0;
                s.we_n = 1'b0;
            end
            PH_WR_DRV: begin
                s.ce_n = 1'b0;
                s.we_n = 1'b0;
                s.drv  = 1'b1;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned CNT_W = 2,
    parameter int unsigned N_RD  = 3,
    parameter int unsigned N_OHZ = 1,
    parameter int unsigned N_WHZ = 1,
    parameter int unsigned N_DRV = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             ack_set,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output phase_e           ph_nxt
);

    localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] LD_OHZ = CNT_W'(N_OHZ - 1);
    localparam logic [CNT_W-1:0] LD_WHZ = CNT_W'(N_WHZ - 1);
    localparam logic [CNT_W-1:0] LD_DRV = CNT_W'(N_DRV - 1);

    phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_nxt;
    end

    assign req_ready = (ph_q == PH_IDLE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        ph_nxt   = ph_q;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        ack_set  = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (req_valid) begin
                    load = 1'b1;
                    if (req_write) begin
                        ph_nxt   = PH_WR_FLT;
                        load_val = LD_WHZ;
                    end else begin
                        ph_nxt   = PH_RD_ACC;
                        load_val = LD_RD;
                    end
                end
            end
            PH_RD_ACC: begin
                if (expired) begin
                    ph_nxt   = PH_RD_FLT;
                    load     = 1'b1;
                    load_val = LD_OHZ;
                    capture  = 1'b1;
                    ack_set  = 1'b1;
                end
            end
            PH_RD_FLT: begin
                if (expired) ph_nxt = PH_IDLE;
            end
            PH_WR_FLT: begin
                if (expired) begin
                    ph_nxt   = PH_WR_DRV;
                    load     = 1'b1;
                    load_val = LD_DRV;
                end
            end
            PH_WR_DRV: begin
                if (expired) begin
                    ph_nxt  = PH_WR_END;
                    ack_set = 1'b1;
                end
            end
            PH_WR_END: ph_nxt = PH_IDLE;
            default:   ph_nxt = PH_IDLE;
        endcase
    end

endmodule

// File: rtl/asram_pins.sv
module asram_pins
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            ph_nxt,
    input  logic              accept,
    input  logic              capture,
    input  logic              ack_set,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    strobe_t nxt_s;
    strobe_t pin_q;

    assign nxt_s = strobes_for(ph_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q     <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
            rsp_valid <= 1'b0;
        end else begin
            pin_q     <= nxt_s;
            rsp_valid <= ack_set;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr      <= '0;
            dq_out    <= '0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                addr   <= req_addr;
                dq_out <= req_wdata;
            end
            if (capture) rsp_rdata <= dq_in;
        end
    end

    assign ce_n  = pin_q.ce_n;
    assign oe_n  = pin_q.oe_n;
    assign we_n  = pin_q.we_n;
    assign dq_oe = pin_q.drv;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CLK_PS   = 4000,
    parameter int unsigned T_AA_PS  = 10000,
    parameter int unsigned T_OE_PS  = 4000,
    parameter int unsigned T_RC_PS  = 10000,
    parameter int unsigned T_OHZ_PS = 4000,
    parameter int unsigned T_WHZ_PS = 4000,
    parameter int unsigned T_WP_PS  = 7000,
    parameter int unsigned T_DW_PS  = 5000,
    parameter int unsigned T_WC_PS  = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int unsigned N_RD  = max2(max2(cyc_ceil(T_AA_PS, CLK_PS),
                                              cyc_ceil(T_OE_PS, CLK_PS)),
                                         cyc_ceil(T_RC_PS, CLK_PS));
    localparam int unsigned N_OHZ = cyc_ceil(T_OHZ_PS, CLK_PS);
    localparam int unsigned N_WHZ = cyc_ceil(T_WHZ_PS, CLK_PS);
    localparam int unsigned N_WLO = max2(cyc_ceil(T_WP_PS, CLK_PS),
                                         cyc_ceil(T_WC_PS, CLK_PS));
    localparam int unsigned N_DRV = max2(cyc_ceil(T_DW_PS, CLK_PS),
                                         (N_WLO > N_WHZ) ? (N_WLO - N_WHZ) : 1);
    localparam int unsigned N_MAX = max2(max2(N_RD, N_OHZ), max2(N_WHZ, N_DRV));
    localparam int unsigned CNT_W = $clog2(N_MAX + 1);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             accept;
    logic             capture;
    logic             ack_set;
    phase_e           ph_nxt;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    asram_seq #(
        .CNT_W (CNT_W),
        .N_RD  (N_RD),
        .N_OHZ (N_OHZ),
        .N_WHZ (N_WHZ),
        .N_DRV (N_DRV)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .expired   (expired),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .ack_set   (ack_set),
        .load      (load),
        .load_val  (load_val),
        .ph_nxt    (ph_nxt)
    );

    asram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .ph_nxt    (ph_nxt),
        .accept    (accept),
        .capture   (capture),
        .ack_set   (ack_set),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (sram_dq_in),
        .addr      (sram_addr),
        .ce_n      (sram_ce_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n),
        .dq_out    (sram_dq_out),
        .dq_oe     (sram_dq_oe),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              sram_dq_oe
);

    assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> (!sram_we_n && sram_oe_n));

    assert_write_strobes_R11: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n));

    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |=> (sram_ce_n || $stable(sram_addr)));

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> !req_ready);

    assert_ack_single_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_float_gap_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> (sram_ce_n && !req_ready));

    assert_drive_release_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> !sram_dq_oe);

    assert_drive_late_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> !sram_dq_oe);

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

    localparam int N_RD  = 3;
    localparam int N_WLO = 3;
    localparam int N_WHZ = 1;
    localparam int N_DRV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in;

    logic [7:0]  mem [256];

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    asram_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // RAM model: drives only when selected for reading
    assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[7:0]] : 8'h00;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h96;
        end else if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
            mem[sram_addr[7:0]] <= sram_dq_out;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_txn(input bit wr, input logic [16:0] a,
                          input logic [7:0] d, input logic [7:0] exp_rd);
        int lo = 0, drv = 0, first_drv = -1, cyc = 0;
        int bad_addr = 0, bad_oe = 0, bad_data = 0;
        logic [7:0] prev_rd;
        @(negedge clk);
        prev_rd = rsp_rdata;
        chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!sram_ce_n && cyc < 50) begin
            if (sram_addr != a) bad_addr++;
            if (wr) begin
                if (!sram_oe_n) bad_oe++;
                if (!sram_we_n) lo++;
                if (sram_dq_oe) begin
                    drv++;
                    if (first_drv < 0) first_drv = cyc;
                    if (sram_dq_out != d) bad_data++;
                end
            end else begin
                if (!sram_oe_n && sram_we_n) lo++;
                if (!sram_we_n || sram_dq_oe) bad_oe++;
            end
            cyc++;
            @(negedge clk);
        end
        chk(bad_addr == 0, "R10 address stable", bad_addr, 0);
        if (wr) begin
            chk(lo == N_WLO && cyc == N_WLO, "R6 write pulse length", lo, N_WLO);
            chk(bad_oe == 0, "R6 oe_n high in write", bad_oe, 0);
            chk(drv == N_DRV, "R7 drive cycles", drv, N_DRV);
            chk(first_drv == N_WHZ, "R7 drive start", first_drv, N_WHZ);
            chk(bad_data == 0, "R7 drive data", bad_data, 0);
            chk(!sram_dq_oe && sram_we_n && sram_oe_n, "R8 strobes idle at ack", sram_dq_oe, 0);
            chk(rsp_valid == 1'b1, "R8 write ack", rsp_valid, 1);
            chk(rsp_rdata == prev_rd, "R8 rdata kept", rsp_rdata, prev_rd);
        end else begin
            chk(lo == N_RD && cyc == N_RD, "R3 read window", lo, N_RD);
            chk(bad_oe == 0, "R3 read strobes", bad_oe, 0);
            chk(rsp_valid == 1'b1, "R4 read ack", rsp_valid, 1);
            chk(rsp_rdata == exp_rd, "R4 read data", rsp_rdata, exp_rd);
            chk(req_ready == 1'b0 && sram_oe_n, "R5 float gap", req_ready, 0);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R4 R8 ack one cycle", rsp_valid, 0);
        chk(req_ready == 1'b1, "R5 idle after gap", req_ready, 1);
    endtask

    // {write, addr, wdata, expected read byte}
    localparam logic [33:0] VEC [10] = '{
        {1'b1, 17'h12345, 8'hA5, 8'h00},
        {1'b1, 17'h000FF, 8'h3C, 8'h00},
        {1'b0, 17'h12345, 8'h00, 8'hA5},
        {1'b0, 17'h000FF, 8'h00, 8'h3C},
        {1'b0, 17'h00010, 8'h00, 8'h86},
        {1'b1, 17'h1FF00, 8'h7E, 8'h00},
        {1'b0, 17'h1FF00, 8'h00, 8'h7E},
        {1'b1, 17'h12345, 8'h5A, 8'h00},
        {1'b0, 17'h1FFFF, 8'h00, 8'h3C},
        {1'b0, 17'h12345, 8'h00, 8'h5A}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes high in reset", {sram_ce_n, sram_oe_n, sram_we_n}, 7);
        chk(!sram_dq_oe && !rsp_valid, "R1 drivers off in reset", sram_dq_oe, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && sram_ce_n, "R1 idle after reset", req_ready, 1);

        for (int i = 0; i < 10; i++)
            do_txn(VEC[i][33], VEC[i][32:16], VEC[i][15:8], VEC[i][7:0]);

        // R2: request held during a read must not disturb it
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00010;
        @(negedge clk);
        req_write = 1'b1; req_addr = 17'h0ABCD; req_wdata = 8'hC3;
        bad = 0;
        while (!sram_ce_n) begin
            if (sram_addr != 17'h00010 || !sram_we_n || req_ready) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R2 held request ignored while busy", bad, 0);
        chk(rsp_rdata == 8'h86, "R4 read under held request", rsp_rdata, 8'h86);
        chk(req_ready == 1'b0, "R2 not ready in float gap", req_ready, 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready again", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!sram_we_n && sram_addr == 17'h0ABCD, "R2 held write starts", sram_addr, 17'h0ABCD);
        while (!sram_ce_n) @(negedge clk);
        @(negedge clk);
        do_txn(1'b0, 17'h0ABCD, 8'h00, 8'hC3);

        // R1: reset in the middle of the driven phase
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00001; req_wdata = 8'h11;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(sram_dq_oe == 1'b1, "R7 driving before reset", sram_dq_oe, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_valid,
            "R1 reset mid write", {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 14);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule